// File: doc/BRIEF.md
# Split-Tenure Bus Master Handshake

This block lets one internal requester win and give back a shared system bus that an outside arbiter controls. The address phase and the data phase of a transfer are owned separately. Each has its own grant input and its own shared busy line. The block raises a bus request and waits for the address grant while no other master holds address-busy. It then marks the start of the address phase with a one-cycle transfer-start strobe and drives address-busy until an address acknowledge comes back.

Every acknowledged address phase owes one data phase. The block claims the data bus once the data grant is present and no other master holds data-busy. It then drives data-busy until a transfer acknowledge arrives. Acknowledged addresses wait in a small count, so a new address phase can run while an earlier data phase is still in progress. Neither busy line is simply let go: for one clock it is driven to the inactive level, and on the next clock its output enable drops.

All bus pins are active-low by default (parameter `PIN_ACTIVE_LOW`). The internal logic works active-high. The number of acknowledged addresses that may wait for their data phase is set by `PEND_DEPTH`, which defaults to 2.

Top module: `bus_tenure_master`

## Requirements
- R1: While reset is held, and right after an asynchronous reset in the middle of a transfer, every output pin is at its inactive level (high). Both busy-line output enables are low.
- R2: In idle, when `req_i` is sampled high and the waiting-address count is below `PEND_DEPTH`, the bus request pin goes low from the next cycle. It stays low until the cycle in which transfer start goes low, and it is high in that cycle.
- R3: Transfer start is low for exactly one cycle. That cycle follows the first edge at which address grant is sampled low and external address-busy is sampled high. Address-busy is driven low, with its enable high, starting in that same cycle.
- R4: No address phase starts while address grant is high or external address-busy is low. No data phase starts while data grant is high or external data-busy is low.
- R5: Address-busy stays driven low until address acknowledge is sampled low. This includes the transfer-start cycle itself. In the next cycle the line is driven high with its enable still high, and in the cycle after that the enable is low.
- R6: A data phase may start at the same edge that samples address acknowledge, or at any later edge at which data grant is low and external data-busy is high. Data-busy is then driven low until transfer acknowledge is sampled low. After that it is driven high for one cycle and then released.
- R7: A new address phase may run while a data phase is active. Acknowledged addresses are counted, and each one is later served by one data phase. When `PEND_DEPTH` addresses are waiting, no new bus request is raised until a data phase starts.
- R8: Address acknowledge and transfer acknowledge sampled outside their own phase are ignored. They neither end a phase nor add a waiting address.
- R9: Once the bus request is raised it stays raised until the address phase starts, even if `req_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Internal request for a transfer, active high |
| agnt_i | input | 1 | Address-bus grant pin |
| dgnt_i | input | 1 | Data-bus grant pin |
| abusy_i | input | 1 | Sensed level of the shared address-busy line |
| dbusy_i | input | 1 | Sensed level of the shared data-busy line |
| aack_i | input | 1 | Address acknowledge pin |
| tack_i | input | 1 | Transfer acknowledge pin |
| breq_o | output | 1 | Bus request pin |
| tstart_o | output | 1 | Transfer-start pin |
| abusy_o | output | 1 | Driven value of address-busy |
| abusy_oe_o | output | 1 | Output enable for address-busy |
| dbusy_o | output | 1 | Driven value of data-busy |
| dbusy_oe_o | output | 1 | Output enable for data-busy |

## Verification
The bench checks an acknowledge that arrives in the same cycle as transfer start. A design that waited an extra cycle would hold address-busy too long. It checks a data phase that is claimed at the very edge of the address acknowledge. A design that missed this would lose a cycle or drop the owed data phase. It drives a grant that is present while the other master's busy line is still active, where a faulty design would collide on the bus. Stray acknowledges and a full waiting-address count are also driven: a faulty design would either invent a data phase or overrun the count and raise a request it cannot serve.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [2:0] {
      A_IDLE  = 3'd0,
      A_REQ   = 3'd1,
      A_START = 3'd2,
      A_TEN   = 3'd3,
      A_REL   = 3'd4
   } addr_st_e;

   typedef enum logic [1:0] {
      D_IDLE = 2'd0,
      D_TEN  = 2'd1,
      D_REL  = 2'd2
   } data_st_e;
endpackage

// File: rtl/bt_addr_fsm.sv
module bt_addr_fsm
   import bt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic room,
   input  logic grant,
   input  logic ext_busy,
   input  logic ack,
   output logic breq,
   output logic tstart,
   output logic busy_act,
   output logic busy_oe,
   output logic ack_take
);
   addr_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         A_IDLE:  if (req && room)         st_d = A_REQ;
         A_REQ:   if (grant && !ext_busy)  st_d = A_START;
         A_START: st_d = ack ? A_REL : A_TEN;
         A_TEN:   if (ack)                 st_d = A_REL;
         A_REL:   st_d = A_IDLE;
         default: st_d = A_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= A_IDLE;
      else        st_q <= st_d;
   end

   assign breq     = (st_q == A_REQ);
   assign tstart   = (st_q == A_START);
   assign busy_act = (st_q == A_START) || (st_q == A_TEN);
   assign busy_oe  = busy_act || (st_q == A_REL);
   assign ack_take = busy_act && ack;

   p_ts_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tstart |=> !tstart);
   p_br_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (breq && !tstart) |=> (breq || tstart));
   p_abb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_act && !ack) |=> busy_act);
   p_abb_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_oe && !busy_act) |=> !busy_oe);
endmodule

// File: rtl/bt_data_fsm.sv
module bt_data_fsm
   import bt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic addr_done,
   input  logic grant,
   input  logic ext_busy,
   input  logic ack,
   output logic busy_act,
   output logic busy_oe,
   output logic take
);
   data_st_e st_q, st_d;

   assign take = (st_q == D_IDLE) && (pending || addr_done) && grant && !ext_busy;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         D_IDLE:  if (take) st_d = D_TEN;
         D_TEN:   if (ack)  st_d = D_REL;
         D_REL:   st_d = D_IDLE;
         default: st_d = D_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= D_IDLE;
      else        st_q <= st_d;
   end

   assign busy_act = (st_q == D_TEN);
   assign busy_oe  = (st_q != D_IDLE);

   p_dbb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_act && !ack) |=> busy_act);
   p_dbb_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_oe && !busy_act) |=> !busy_oe);
endmodule

// File: rtl/bt_pend_ctr.sv
module bt_pend_ctr #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nonzero,
   output logic room
);
   localparam int W = $clog2(DEPTH + 1);
   localparam logic [W-1:0] LIMIT = W'(DEPTH);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
      else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
   end

   assign nonzero = (cnt_q != '0);
   assign room    = (cnt_q < LIMIT);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (nonzero || inc));
endmodule

// File: rtl/bus_tenure_master.sv
module bus_tenure_master #(
   parameter int PEND_DEPTH     = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic agnt_i,
   input  logic dgnt_i,
   input  logic abusy_i,
   input  logic dbusy_i,
   input  logic aack_i,
   input  logic tack_i,
   output logic breq_o,
   output logic tstart_o,
   output logic abusy_o,
   output logic abusy_oe_o,
   output logic dbusy_o,
   output logic dbusy_oe_o
);
   if (PEND_DEPTH < 1) begin : g_bad_depth
      $error("PEND_DEPTH must be at least 1");
   end

   logic ag, dg, abx, dbx, aak, tak;
   logic br, ts, a_act, a_oe, d_act, d_oe;
   logic a_take, d_take, pend_nz, pend_room;

   if (PIN_ACTIVE_LOW) begin : g_pins_low
      assign ag       = ~agnt_i;
      assign dg       = ~dgnt_i;
      assign abx      = ~abusy_i;
      assign dbx      = ~dbusy_i;
      assign aak      = ~aack_i;
      assign tak      = ~tack_i;
      assign breq_o   = ~br;
      assign tstart_o = ~ts;
      assign abusy_o  = ~a_act;
      assign dbusy_o  = ~d_act;
   end else begin : g_pins_high
      assign ag       = agnt_i;
      assign dg       = dgnt_i;
      assign abx      = abusy_i;
      assign dbx      = dbusy_i;
      assign aak      = aack_i;
      assign tak      = tack_i;
      assign breq_o   = br;
      assign tstart_o = ts;
      assign abusy_o  = a_act;
      assign dbusy_o  = d_act;
   end

   assign abusy_oe_o = a_oe;
   assign dbusy_oe_o = d_oe;

   bt_addr_fsm u_addr (
      .clk(clk), .rst_n(rst_n), .req(req_i), .room(pend_room),
      .grant(ag), .ext_busy(abx), .ack(aak),
      .breq(br), .tstart(ts), .busy_act(a_act), .busy_oe(a_oe),
      .ack_take(a_take)
   );

   bt_data_fsm u_data (
      .clk(clk), .rst_n(rst_n), .pending(pend_nz), .addr_done(a_take),
      .grant(dg), .ext_busy(dbx), .ack(tak),
      .busy_act(d_act), .busy_oe(d_oe), .take(d_take)
   );

   bt_pend_ctr #(.DEPTH(PEND_DEPTH)) u_pend (
      .clk(clk), .rst_n(rst_n), .inc(a_take), .dec(d_take),
      .nonzero(pend_nz), .room(pend_room)
   );

   p_astart_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts) |-> $past(ag && !abx));
   p_dstart_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(d_act) |-> $past(dg && !dbx));
   p_ts_drops_br_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts) |-> $past(br));
endmodule

// File: tb/bus_tenure_master_tb_top.sv
module bus_tenure_master_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic agnt_i = 1'b1, dgnt_i = 1'b1, abusy_i = 1'b1, dbusy_i = 1'b1;
   logic aack_i = 1'b1, tack_i = 1'b1;
   logic breq_o, tstart_o, abusy_o, abusy_oe_o, dbusy_o, dbusy_oe_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bus_tenure_master dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i),
      .agnt_i(agnt_i), .dgnt_i(dgnt_i), .abusy_i(abusy_i), .dbusy_i(dbusy_i),
      .aack_i(aack_i), .tack_i(tack_i),
      .breq_o(breq_o), .tstart_o(tstart_o), .abusy_o(abusy_o),
      .abusy_oe_o(abusy_oe_o), .dbusy_o(dbusy_o), .dbusy_oe_o(dbusy_oe_o)
   );

   // inputs {req, agnt, dgnt, other abusy, other dbusy, aack, tack} (logical, high = asserted)
   // expected {br, ts, abb_oe, abb_act, dbb_oe, dbb_act} (logical)
   localparam int NV = 44;
   localparam logic [12:0] VEC [0:NV-1] = '{
      13'b1000000_100000, 13'b1000000_100000, 13'b1101000_100000, 13'b1100000_011100,
      13'b0000000_001100, 13'b0000010_001000, 13'b0000000_000000, 13'b0010100_000000,
      13'b0010000_000011, 13'b0000000_000011, 13'b0000001_000010, 13'b0000000_000000,
      13'b1000000_100000, 13'b1100000_011100, 13'b0010010_001011, 13'b1010000_000011,
      13'b1000000_100011, 13'b1100000_011111, 13'b0010010_001011, 13'b0000001_000010,
      13'b0010000_000000, 13'b0010000_000011, 13'b0000001_000010, 13'b0000000_000000,
      13'b1000000_100000, 13'b1100000_011100, 13'b0000010_001000, 13'b1000000_000000,
      13'b1000000_100000, 13'b1100000_011100, 13'b0000010_001000, 13'b1000000_000000,
      13'b1000000_000000, 13'b1010000_000011, 13'b1000000_100011, 13'b1000001_100010,
      13'b0000000_100000, 13'b0010000_100011, 13'b0100001_011110, 13'b0000010_001000,
      13'b0010000_000011, 13'b0000001_000010, 13'b0000011_000000, 13'b0010000_000000
   };

   function automatic string tag_of(int i);
      case (i) inside
         [0:1]:   return "R2";
         2, 7:    return "R4";
         3:       return "R3";
         [4:6]:   return "R5";
         [8:11]:  return "R6";
         14:      return "R6";
         36:      return "R9";
         [42:43]: return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic apply(input logic [6:0] v);
      req_i   = v[6];
      agnt_i  = ~v[5];
      dgnt_i  = ~v[4];
      abusy_i = ~v[3];
      dbusy_i = ~v[2];
      aack_i  = ~v[1];
      tack_i  = ~v[0];
   endtask

   task automatic check(input logic [5:0] e, input string tag);
      logic [5:0] exp_pins, act_pins;
      exp_pins = {~e[5], ~e[4], e[3], ~(e[3] & e[2]), e[1], ~(e[1] & e[0])};
      act_pins = {breq_o, tstart_o, abusy_oe_o, abusy_o, dbusy_oe_o, dbusy_o};
      checks++;
      if (act_pins !== exp_pins) begin
         errors++;
         $display("FAIL %s: pins {breq,tstart,aoe,abusy,doe,dbusy} actual %b expected %b",
                  tag, act_pins, exp_pins);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, actual no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      apply(7'b0);
      repeat (3) @(negedge clk);
      check(6'b000000, "R1");   // R1: idle pins during reset
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][12:6]);
         @(posedge clk);
         @(negedge clk);
         check(VEC[i][5:0], tag_of(i));
      end
      // R1: reset in the middle of an address phase
      apply(7'b1000000);
      @(negedge clk);
      apply(7'b1100000);
      @(negedge clk);
      check(6'b011100, "R3");
      apply(7'b0);
      rst_n = 1'b0;
      #1;
      check(6'b000000, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(6'b000000, "R1");
      // R8: no waiting address survives the reset, so a data grant starts nothing
      apply(7'b0010000);
      @(negedge clk);
      check(6'b000000, "R8");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule